// File: doc/BRIEF.md
# Scanline and Frame Timing Generator

This block produces display line and frame timing from a periodic tick enable. It divides the tick into units, counts units across a line, and counts lines across a frame. A line has a visible part of 256 units followed by a horizontal blank of 99 units, and each unit lasts 12 ticks. A frame has 263 lines. All of these counts are parameters. From these counters the block keeps three hardware flags in a 16-bit status word: vertical blank, horizontal blank and line match. It also raises single-cycle event pulses for the interrupt controller and for the DMA engine.

The CPU reaches the block through a small register port with two selectable registers. The status register holds the hardware flags, three interrupt enables and a 9-bit line compare target. The line register reports the current line. Reads are combinational. A write takes effect at the clock edge where the write strobe is high. Writes to the line register and to the read-only status bits are dropped.

Top module: `scanline_timer`

## Requirements
- R1: After reset the status word reads 0x0000, the line register reads 0, and no event output is high until ticks arrive.
- R2: Counting from the start of a line, the tick that completes TICKS_PER_UNIT×VIS_UNITS ticks sets status bit 1 and pulses `hblank_o` for one cycle. Bit 1 clears when the next line begins.
- R3: Each line lasts TICKS_PER_UNIT×(VIS_UNITS+HBL_UNITS) ticks. The line register then advances by one, and after line NUM_LINES−1 it returns to 0.
- R4: When the line count enters VBL_LINE, status bit 0 is set and `vblank_o` pulses. `vblank_irq_o` also pulses if status bit 3 is set. Bit 0 clears when the line count returns to 0.
- R5: The compare target is the 9-bit value {status[7], status[15:8]}. On each line entry, status bit 2 becomes 1 if the new line equals the target and 0 otherwise. A match pulses `line_match_irq_o` when status bit 5 is set.
- R6: `hblank_dma_o` pulses together with `hblank_o`, but only while the current line is below VBL_LINE.
- R7: `hblank_irq_o` pulses together with `hblank_o` only when status bit 4 is set.
- R8: Writes leave status bits 0, 1, 2 and 6 untouched, and bit 6 reads 0. Writes to the line register (select 1) have no effect.
- R9: A status write that lands on a line-entry edge has these effects at that edge: the flags take their hardware update, the writable fields take the written value, and the compare and its interrupt use the target and enable held before the write.
- R10: Nothing advances on a cycle where `tick_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Timing tick enable |
| reg_wr_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | 0 selects status, 1 selects line |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data of the selected register |
| hblank_o | output | 1 | Horizontal blank start pulse |
| hblank_irq_o | output | 1 | Horizontal blank interrupt pulse |
| hblank_dma_o | output | 1 | Horizontal blank DMA trigger pulse |
| vblank_o | output | 1 | Vertical blank start pulse |
| vblank_irq_o | output | 1 | Vertical blank interrupt pulse |
| line_match_irq_o | output | 1 | Line match interrupt pulse |

## Verification
A CPU write to the status register can fall on the very edge where the hardware enters a new line and rewrites the flags and the match result. The bench provokes this by issuing the write on the final tick of a line. In that write it changes the target and the enables and also tries to set the read-only flags. It then judges two things. First, the match pulse and bit 2 must follow the old target and enable. Second, the readback must show the new writable fields next to the hardware-owned flags. A scoreboard compares every event pulse against a tick-indexed model over full frames, which covers the DMA gating in the blank lines.

// File: rtl/scanline_pkg.sv
package scanline_pkg;
  localparam int LINE_W = 9;
  localparam int REG_W  = 16;

  // status word bit positions (software decodes these)
  localparam int BIT_VBL      = 0;
  localparam int BIT_HBL      = 1;
  localparam int BIT_MATCH    = 2;
  localparam int BIT_VIRQ_EN  = 3;
  localparam int BIT_HIRQ_EN  = 4;
  localparam int BIT_MIRQ_EN  = 5;
  localparam int BIT_TGT_HI   = 7;
  localparam int TGT_LO_LSB   = 8;

  // bits the CPU may write: 3..5 and 7..15
  localparam logic [REG_W-1:0] CTRL_MASK = 16'hFFB8;

  typedef enum logic {
    SEL_STATUS = 1'b0,
    SEL_LINE   = 1'b1
  } reg_sel_e;

  typedef struct packed {
    logic match;
    logic hbl;
    logic vbl;
  } flags_t;
endpackage

// File: rtl/sl_phase_counter.sv
module sl_phase_counter #(
  parameter int TICKS_PER_UNIT = 12,
  parameter int VIS_UNITS      = 256,
  parameter int HBL_UNITS      = 99
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  output logic hb_begin,
  output logic line_end
);
  localparam int LINE_UNITS = VIS_UNITS + HBL_UNITS;
  localparam int UCNT_W     = (LINE_UNITS > 1) ? $clog2(LINE_UNITS) : 1;

  logic unit_stb;

  generate
    if (TICKS_PER_UNIT > 1) begin : g_prescale
      localparam int PCNT_W = $clog2(TICKS_PER_UNIT);
      logic [PCNT_W-1:0] pcnt;
      assign unit_stb = tick && (pcnt == PCNT_W'(TICKS_PER_UNIT - 1));
      always_ff @(posedge clk) begin
        if (!rst_n)    pcnt <= '0;
        else if (tick) pcnt <= unit_stb ? '0 : pcnt + 1'b1;
      end
    end else begin : g_direct
      assign unit_stb = tick;
    end
  endgenerate

  logic [UCNT_W-1:0] ucnt;
  logic              last_unit;

  assign last_unit = (ucnt == UCNT_W'(LINE_UNITS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)        ucnt <= '0;
    else if (unit_stb) ucnt <= last_unit ? '0 : ucnt + 1'b1;
  end

  assign hb_begin = unit_stb && (ucnt == UCNT_W'(VIS_UNITS - 1));
  assign line_end = unit_stb && last_unit;
endmodule

// File: rtl/sl_line_counter.sv
module sl_line_counter
  import scanline_pkg::*;
#(
  parameter int NUM_LINES = 263,
  parameter int VBL_LINE  = 192
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  output logic [LINE_W-1:0] line_q,
  output logic [LINE_W-1:0] line_nxt,
  output logic              enter_vbl,
  output logic              wrap,
  output logic              visible
);
  assign line_nxt = (line_q == LINE_W'(NUM_LINES - 1)) ? '0 : line_q + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n)    line_q <= '0;
    else if (step) line_q <= line_nxt;
  end

  assign enter_vbl = step && (line_nxt == LINE_W'(VBL_LINE));
  assign wrap      = step && (line_nxt == '0);
  assign visible   = (line_q < LINE_W'(VBL_LINE));
endmodule

// File: rtl/sl_line_compare.sv
module sl_line_compare
  import scanline_pkg::*;
(
  input  logic [7:0]        tgt_lo,
  input  logic              tgt_hi,
  input  logic [LINE_W-1:0] line_nxt,
  output logic              hit
);
  logic [LINE_W-1:0] target;
  assign target = {tgt_hi, tgt_lo};
  assign hit    = (line_nxt == target);
endmodule

// File: rtl/sl_status_reg.sv
module sl_status_reg
  import scanline_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wdata,
  input  logic             hb_begin,
  input  logic             line_step,
  input  logic             enter_vbl,
  input  logic             wrap,
  input  logic             hit,
  output logic [REG_W-1:0] status_q
);
  flags_t           flags;
  logic [REG_W-1:0] ctrl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags <= '0;
    end else begin
      if (wrap)           flags.vbl <= 1'b0;
      else if (enter_vbl) flags.vbl <= 1'b1;
      if (line_step)      flags.hbl <= 1'b0;
      else if (hb_begin)  flags.hbl <= 1'b1;
      if (line_step)      flags.match <= hit;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     ctrl_q <= '0;
    else if (wr_en) ctrl_q <= wdata & CTRL_MASK;
  end

  assign status_q = ctrl_q | {{(REG_W-3){1'b0}}, flags.match, flags.hbl, flags.vbl};
endmodule

// File: rtl/scanline_timer.sv
module scanline_timer
  import scanline_pkg::*;
#(
  parameter int TICKS_PER_UNIT = 12,
  parameter int VIS_UNITS      = 256,
  parameter int HBL_UNITS      = 99,
  parameter int NUM_LINES      = 263,
  parameter int VBL_LINE       = 192
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_i,
  input  logic        reg_wr_i,
  input  logic        reg_sel_i,
  input  logic [15:0] reg_wdata_i,
  output logic [15:0] reg_rdata_o,
  output logic        hblank_o,
  output logic        hblank_irq_o,
  output logic        hblank_dma_o,
  output logic        vblank_o,
  output logic        vblank_irq_o,
  output logic        line_match_irq_o
);
  logic              hb_begin, line_end;
  logic [LINE_W-1:0] line_q, line_nxt;
  logic              enter_vbl, wrap, visible, hit;
  logic [REG_W-1:0]  status_q;
  logic              stat_wr;

  sl_phase_counter #(
    .TICKS_PER_UNIT(TICKS_PER_UNIT),
    .VIS_UNITS     (VIS_UNITS),
    .HBL_UNITS     (HBL_UNITS)
  ) u_phase (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick_i),
    .hb_begin(hb_begin),
    .line_end(line_end)
  );

  sl_line_counter #(
    .NUM_LINES(NUM_LINES),
    .VBL_LINE (VBL_LINE)
  ) u_line (
    .clk      (clk),
    .rst_n    (rst_n),
    .step     (line_end),
    .line_q   (line_q),
    .line_nxt (line_nxt),
    .enter_vbl(enter_vbl),
    .wrap     (wrap),
    .visible  (visible)
  );

  sl_line_compare u_cmp (
    .tgt_lo  (status_q[TGT_LO_LSB +: 8]),
    .tgt_hi  (status_q[BIT_TGT_HI]),
    .line_nxt(line_nxt),
    .hit     (hit)
  );

  assign stat_wr = reg_wr_i && (reg_sel_i == SEL_STATUS);

  sl_status_reg u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (stat_wr),
    .wdata    (reg_wdata_i),
    .hb_begin (hb_begin),
    .line_step(line_end),
    .enter_vbl(enter_vbl),
    .wrap     (wrap),
    .hit      (hit),
    .status_q (status_q)
  );

  // events use the enables held before any write on the same edge
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hblank_o         <= 1'b0;
      hblank_irq_o     <= 1'b0;
      hblank_dma_o     <= 1'b0;
      vblank_o         <= 1'b0;
      vblank_irq_o     <= 1'b0;
      line_match_irq_o <= 1'b0;
    end else begin
      hblank_o         <= hb_begin;
      hblank_irq_o     <= hb_begin && status_q[BIT_HIRQ_EN];
      hblank_dma_o     <= hb_begin && visible;
      vblank_o         <= enter_vbl;
      vblank_irq_o     <= enter_vbl && status_q[BIT_VIRQ_EN];
      line_match_irq_o <= line_end && hit && status_q[BIT_MIRQ_EN];
    end
  end

  assign reg_rdata_o = (reg_sel_i == SEL_LINE) ? {{(REG_W-LINE_W){1'b0}}, line_q} : status_q;
endmodule

// File: rtl/sl_timing_checker.sv
module sl_timing_checker
  import scanline_pkg::*;
#(
  parameter int NUM_LINES = 263,
  parameter int VBL_LINE  = 192
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick_i,
  input logic [LINE_W-1:0] line_q,
  input logic              flag_vbl,
  input logic              flag_hbl,
  input logic              flag_match,
  input logic              hblank_o,
  input logic              hblank_irq_o,
  input logic              hblank_dma_o,
  input logic              vblank_o,
  input logic              line_match_irq_o
);
  a_r2_hblank_flag: assert property (@(posedge clk) disable iff (!rst_n)
    hblank_o |-> flag_hbl);

  a_r3_line_range: assert property (@(posedge clk) disable iff (!rst_n)
    line_q < LINE_W'(NUM_LINES));

  a_r3_line_step: assert property (@(posedge clk) disable iff (!rst_n)
    (line_q != $past(line_q)) |-> ((line_q == $past(line_q) + 1'b1) || (line_q == '0)));

  a_r4_vblank_entry: assert property (@(posedge clk) disable iff (!rst_n)
    vblank_o |-> (flag_vbl && (line_q == LINE_W'(VBL_LINE))));

  a_r4_vblank_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_vbl) |-> (line_q == '0));

  a_r5_match_flag: assert property (@(posedge clk) disable iff (!rst_n)
    line_match_irq_o |-> flag_match);

  a_r6_dma_visible: assert property (@(posedge clk) disable iff (!rst_n)
    hblank_dma_o |-> (hblank_o && (line_q < LINE_W'(VBL_LINE))));

  a_r7_hirq_with_hblank: assert property (@(posedge clk) disable iff (!rst_n)
    hblank_irq_o |-> hblank_o);

  a_r10_hold_line: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(line_q));
endmodule

bind scanline_timer sl_timing_checker #(
  .NUM_LINES(NUM_LINES),
  .VBL_LINE (VBL_LINE)
) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .tick_i          (tick_i),
  .line_q          (line_q),
  .flag_vbl        (status_q[0]),
  .flag_hbl        (status_q[1]),
  .flag_match      (status_q[2]),
  .hblank_o        (hblank_o),
  .hblank_irq_o    (hblank_irq_o),
  .hblank_dma_o    (hblank_dma_o),
  .vblank_o        (vblank_o),
  .line_match_irq_o(line_match_irq_o)
);

// File: tb/sim_scanline_timer.sv
`timescale 1ns/1ps
module sim_scanline_timer;
  localparam int TPU = 2, VIS = 3, HBL = 2, NL = 12, VBL = 8;
  localparam int LT = TPU * (VIS + HBL);
  localparam int VT = TPU * VIS;
  localparam logic [15:0] WMASK = 16'hFFB8;

  logic clk = 0, rst_n = 0, tick = 0, reg_wr = 0, reg_sel = 0;
  logic [15:0] reg_wdata = '0, reg_rdata;
  logic hb, hirq, hdma, vb, virq, mirq;

  always #10 clk = ~clk;

  scanline_timer #(.TICKS_PER_UNIT(TPU), .VIS_UNITS(VIS), .HBL_UNITS(HBL),
                   .NUM_LINES(NL), .VBL_LINE(VBL)) u0 (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .reg_wr_i(reg_wr), .reg_sel_i(reg_sel),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .hblank_o(hb), .hblank_irq_o(hirq),
    .hblank_dma_o(hdma), .vblank_o(vb), .vblank_irq_o(virq), .line_match_irq_o(mirq));

  int checks = 0, errors = 0;
  // event vector: 0 hblank, 1 hblank irq, 2 dma, 3 vblank, 4 vblank irq, 5 match irq
  typedef struct { int stamp; logic [5:0] ev; } exp_t;
  exp_t sbq[$];
  int drv_n = 0, ref_h = 0, ref_line = 0;
  logic [15:0] cfg = '0;
  bit mon_on = 0;

  task automatic check(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic string ev_req(logic [5:0] d);
    if (d[0]) return "R2";
    if (d[1]) return "R7";
    if (d[2]) return "R6";
    if (d[3] || d[4]) return "R4";
    return "R5";
  endfunction

  // driver: one tick, optional status write on the same edge
  task automatic step(bit wr, logic [15:0] wd);
    logic [5:0] e;
    logic [8:0] tgt;
    e = '0;
    tgt = {cfg[7], cfg[15:8]};
    @(negedge clk);
    tick = 1; reg_wr = wr; reg_sel = 0; reg_wdata = wd;
    drv_n++; ref_h++;
    if (ref_h == VT) begin
      e[0] = 1'b1; e[1] = cfg[4]; e[2] = (ref_line < VBL);
    end
    if (ref_h == LT) begin
      ref_h = 0;
      ref_line = (ref_line + 1) % NL;
      e[3] = (ref_line == VBL);
      e[4] = e[3] & cfg[3];
      e[5] = (9'(ref_line) == tgt) & cfg[5];
    end
    if (e != 0) sbq.push_back('{drv_n, e});
    if (wr) cfg = wd & WMASK;
  endtask

  task automatic idle(int n);
    @(negedge clk);
    tick = 0; reg_wr = 0;
    repeat (n - 1) @(negedge clk);
  endtask

  task automatic wr_reg(bit sel, logic [15:0] wd);
    @(negedge clk);
    tick = 0; reg_wr = 1; reg_sel = sel; reg_wdata = wd;
    if (!sel) cfg = wd & WMASK;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(bit sel, output logic [15:0] v);
    reg_sel = sel;
    #1 v = reg_rdata;
  endtask

  task automatic goto_line(int l);
    while (!(ref_line == l && ref_h == 0)) step(0, '0);
    idle(2);
  endtask

  // monitor / scoreboard
  initial begin
    int cur;
    logic [5:0] obs, ex;
    exp_t t;
    cur = 0;
    forever begin
      @(posedge clk);
      #5;
      if (mon_on) begin
        obs = {mirq, virq, vb, hdma, hirq, hb};
        ex = '0;
        if (tick) begin
          cur++;
          if (sbq.size() > 0 && sbq[0].stamp == cur) begin
            t = sbq.pop_front();
            ex = t.ev;
          end
        end
        checks++;
        if (obs !== ex) begin
          errors++;
          $display("FAIL %s: events actual=%b expected=%b at tick %0d", ev_req(obs ^ ex), obs, ex, cur);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R10 watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    mon_on = 1;
    // R1 reset state
    rd(0, v); check("R1 status", v, 16'h0000);
    rd(1, v); check("R1 line", v, 0);
    // R8 read-only bits and line register writes
    wr_reg(0, 16'h037F);
    rd(0, v); check("R8 status ro bits", v, 16'h0338);
    wr_reg(1, 16'h01FF);
    rd(1, v); check("R8 line write ignored", v, 0);
    // R10 no ticks
    idle(5);
    rd(1, v); check("R10 line held", v, 0);
    rd(0, v); check("R10 status held", v, 16'h0338);
    // R2 hblank flag timing
    repeat (VT - 1) step(0, '0);
    idle(2);
    rd(0, v); check("R2 hbl before start", v[1], 0);
    step(0, '0); idle(2);
    rd(0, v); check("R2 hbl set", v[1], 1);
    repeat (LT - VT) step(0, '0);
    idle(2);
    rd(1, v); check("R3 line 1", v, 1);
    rd(0, v); check("R2 hbl cleared", v[1], 0);
    // R5 match at target 3
    goto_line(3);
    rd(0, v); check("R5 match set", v[2], 1);
    goto_line(4);
    rd(0, v); check("R5 match cleared", v[2], 0);
    // R4 vblank
    goto_line(VBL);
    rd(0, v); check("R4 vbl set", v[0], 1);
    rd(1, v); check("R4 line vbl", v, VBL);
    goto_line(NL - 1);
    rd(1, v); check("R3 last line", v, NL - 1);
    goto_line(0);
    rd(1, v); check("R3 wrap", v, 0);
    rd(0, v); check("R4 vbl cleared", v[0], 0);
    // R5 bit 8 of target: 0x103 never equals line 3; R7 hblank irq off
    wr_reg(0, 16'h03A8);
    goto_line(3);
    rd(0, v); check("R5 target bit8", v, 16'h03A8);
    // R9 write on the line-entry edge
    wr_reg(0, 16'h0420);
    while (ref_h != LT - 1) step(0, '0);
    step(1, 16'h0512);
    idle(2);
    rd(0, v); check("R9 merged status", v, 16'h0514);
    rd(1, v); check("R9 line", v, 4);
    goto_line(5);
    rd(0, v); check("R5 new target flag", v, 16'h0514);
    // full frame for R6 dma gating through the blank lines
    goto_line(0);
    goto_line(2);
    idle(4);
    check("R6 scoreboard drained", sbq.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule